// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory operation into a stream of per-element memory requests. A start pulse captures a base address, a stride, an addressing mode, a direction (load or store) and an element count. The block then issues one request per accepted handshake, each tagged with its element number. In unit-stride mode the elements are contiguous. In strided mode they are spaced by a run-time stride. In indexed mode the offset of each element comes from an index vector register. This gives a gather for loads and a scatter for stores.

The vector registers sit outside the block behind one shared read port with a single cycle of latency. The same element number addresses both the index register and the store-source register. For loads, the memory returns responses in request order, and the block writes each returned word into the destination register at increasing element positions. For stores, each request carries the source element as write data. The addresses count elements rather than bytes. Because the whole access pattern is known when the operation starts, requests go out back to back with no data-dependent decisions.

Top module: `vec_agu`

## Requirements
- R1: With `op_mode` = 0 (unit stride; value 3 behaves the same), the request for element i carries address base + i, modulo 2^32.
- R2: With `op_mode` = 1 (strided), the request for element i carries address base + i × stride, modulo 2^32. The stride is a two's-complement value, so negative strides and wrap-around both work.
- R3: With `op_mode` = 2 (indexed), the request for element i carries address base + idx[i], modulo 2^32. Here idx[i] is the word returned on `vr_idx_data` one cycle after `vr_rd_addr` = i.
- R4: An operation issues exactly min(`op_vlen`, 64) requests, tagged 0, 1, 2, … in increasing order on `mem_req_elem`. No request is valid while `busy` is low.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, element tag, write flag and write data do not change.
- R6: With `mem_req_ready` held high, one request is accepted on every clock cycle from the first to the last element.
- R7: For a store, `mem_req_we` is 1 and `mem_req_wdata` of element i equals the source word read at element address i. For a load, `mem_req_we` is 0.
- R8: For a load, the k-th accepted `mem_rsp_valid` word is written through `dst_we`/`dst_addr`/`dst_data` to element k, one cycle after that response. Stores produce no destination writes.
- R9: `done` is high for exactly one cycle. For a store, it rises in the cycle after the final request is accepted. For a load, it rises together with the final destination write. With a count of 0, no request is issued and `done` rises in the cycle after `start`. `busy` is low whenever `done` is high.
- R10: A `start` pulse while `busy` is high is ignored. The running operation is not disturbed and no extra requests appear.
- R11: An `op_vlen` above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| op_base | input | 32 | Base element address |
| op_stride | input | 32 | Stride in elements (two's complement) |
| op_vlen | input | 7 | Element count, clamped to 64 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vr_rd_addr | output | 6 | Element number for the index/source register read |
| vr_idx_data | input | 32 | Index element, one cycle after vr_rd_addr |
| vr_src_data | input | 32 | Source element, one cycle after vr_rd_addr |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Element address |
| mem_req_we | output | 1 | Write request |
| mem_req_wdata | output | 32 | Store data |
| mem_req_elem | output | 6 | Element tag |
| mem_rsp_valid | input | 1 | Load data returning (in order) |
| mem_rsp_data | input | 32 | Load data |
| dst_we | output | 1 | Destination register write enable |
| dst_addr | output | 6 | Destination element |
| dst_data | output | 32 | Destination write data |

## Verification
A corrupt running address shows up at the ports as a wrong `mem_req_addr` on the very next accepted request, and every request after it is also wrong. An element counter that slips shows up as a skipped or repeated tag, or as a `done` that comes too early or never comes. The first sign appears within one handshake. A response counter out of step puts load data into the wrong destination element on the next response. The scoreboard compares every request and every destination write against values computed from the requirements, so each of these faults is caught at the first transfer it touches.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    VA_UNIT   = 2'd0,
    VA_STRIDE = 2'd1,
    VA_INDEX  = 2'd2,
    VA_UNIT2  = 2'd3
  } va_mode_e;
endpackage

// File: rtl/vagu_addr_gen.sv
// Running address accumulator plus indexed-mode adder.
module vagu_addr_gen
  import vagu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [1:0]    mode_in,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] stride_in,
  input  logic          advance,
  input  logic [AW-1:0] idx_data,
  output logic [AW-1:0] addr_next
);
  va_mode_e      mode_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] step_q;
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= VA_UNIT;
      base_q <= '0;
      step_q <= AW'(1);
      acc_q  <= '0;
    end else if (accept) begin
      mode_q <= va_mode_e'(mode_in);
      base_q <= base_in;
      step_q <= (va_mode_e'(mode_in) == VA_STRIDE) ? stride_in : AW'(1);
      acc_q  <= base_in;
    end else if (advance) begin
      acc_q  <= acc_q + step_q;
    end
  end

  always_comb begin
    if (mode_q == VA_INDEX) addr_next = base_q + idx_data;
    else                    addr_next = acc_q;
  end
endmodule

// File: rtl/vagu_issue.sv
// Element counter, register read look-ahead and request output register.
module vagu_issue #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int EW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          busy,
  input  logic [LW-1:0] vlen,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] src_data,
  input  logic          req_ready,
  output logic          advance,
  output logic [EW-1:0] rd_addr,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [EW-1:0] req_elem
);
  logic [LW-1:0] load_cnt;
  logic [EW-1:0] cur_elem;

  assign cur_elem = load_cnt[EW-1:0];
  assign advance  = busy && (load_cnt < vlen) && (!req_valid || req_ready);

  // Present the element that will be needed at the next load so the
  // one-cycle register read never stalls the stream.
  always_comb begin
    if (accept)       rd_addr = '0;
    else if (advance) rd_addr = cur_elem + EW'(1);
    else              rd_addr = cur_elem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_cnt  <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_elem  <= '0;
    end else if (accept) begin
      load_cnt  <= '0;
      req_valid <= 1'b0;
    end else if (advance) begin
      load_cnt  <= load_cnt + LW'(1);
      req_valid <= 1'b1;
      req_addr  <= addr_in;
      req_wdata <= src_data;
      req_elem  <= cur_elem;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vagu_resp.sv
// In-order load response sink writing the destination register.
module vagu_resp #(
  parameter int DW = 32,
  parameter int EW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          busy,
  input  logic          is_load,
  input  logic [LW-1:0] vlen,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          last,
  output logic          dst_we,
  output logic [EW-1:0] dst_addr,
  output logic [DW-1:0] dst_data
);
  logic [LW-1:0] rsp_cnt;
  logic          take;

  assign take = busy && is_load && rsp_valid && (rsp_cnt < vlen);
  assign last = take && (rsp_cnt == vlen - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_cnt  <= '0;
      dst_we   <= 1'b0;
      dst_addr <= '0;
      dst_data <= '0;
    end else begin
      dst_we <= take;
      if (accept) begin
        rsp_cnt <= '0;
      end else if (take) begin
        rsp_cnt  <= rsp_cnt + LW'(1);
        dst_addr <= rsp_cnt[EW-1:0];
        dst_data <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/vec_agu.sv
module vec_agu #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int MAXVL = 64,
  localparam int EW   = $clog2(MAXVL),
  localparam int LW   = $clog2(MAXVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_store,
  input  logic [1:0]    op_mode,
  input  logic [AW-1:0] op_base,
  input  logic [AW-1:0] op_stride,
  input  logic [LW-1:0] op_vlen,
  output logic          busy,
  output logic          done,
  output logic [EW-1:0] vr_rd_addr,
  input  logic [AW-1:0] vr_idx_data,
  input  logic [DW-1:0] vr_src_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_wdata,
  output logic [EW-1:0] mem_req_elem,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          dst_we,
  output logic [EW-1:0] dst_addr,
  output logic [DW-1:0] dst_data
);
  logic          accept;
  logic [LW-1:0] vlen_clamped;
  logic [LW-1:0] vlen_q;
  logic          store_q;
  logic          advance;
  logic [AW-1:0] addr_next;
  logic          rsp_last;
  logic          store_last;
  logic          finish;

  assign accept       = start && !busy;
  assign vlen_clamped = (op_vlen > LW'(MAXVL)) ? LW'(MAXVL) : op_vlen;
  assign store_last   = store_q && busy && mem_req_valid && mem_req_ready &&
                        (LW'(mem_req_elem) == vlen_q - LW'(1));
  assign finish       = store_last || rsp_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      vlen_q     <= '0;
      store_q    <= 1'b0;
      mem_req_we <= 1'b0;
    end else begin
      done <= finish || (accept && vlen_clamped == '0);
      if (accept) begin
        busy       <= (vlen_clamped != '0);
        vlen_q     <= vlen_clamped;
        store_q    <= op_store;
        mem_req_we <= op_store;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  vagu_addr_gen #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .mode_in   (op_mode),
    .base_in   (op_base),
    .stride_in (op_stride),
    .advance   (advance),
    .idx_data  (vr_idx_data),
    .addr_next (addr_next)
  );

  vagu_issue #(.AW(AW), .DW(DW), .EW(EW), .LW(LW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .busy      (busy),
    .vlen      (vlen_q),
    .addr_in   (addr_next),
    .src_data  (vr_src_data),
    .req_ready (mem_req_ready),
    .advance   (advance),
    .rd_addr   (vr_rd_addr),
    .req_valid (mem_req_valid),
    .req_addr  (mem_req_addr),
    .req_wdata (mem_req_wdata),
    .req_elem  (mem_req_elem)
  );

  vagu_resp #(.DW(DW), .EW(EW), .LW(LW)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .busy      (busy),
    .is_load   (!store_q),
    .vlen      (vlen_q),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .last      (rsp_last),
    .dst_we    (dst_we),
    .dst_addr  (dst_addr),
    .dst_data  (dst_data)
  );
endmodule

// File: rtl/vec_agu_chk.sv
module vec_agu_chk #(
  parameter int AW = 32,
  parameter int MAXVL = 64,
  localparam int EW = $clog2(MAXVL),
  localparam int LW = $clog2(MAXVL + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    op_mode,
  input logic [AW-1:0] op_base,
  input logic [LW-1:0] op_vlen,
  input logic          busy,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_wdata,
  input logic [EW-1:0] mem_req_elem,
  input logic          dst_we,
  input logic [EW-1:0] dst_addr
);
  logic [LW-1:0] hs_cnt;
  logic [LW-1:0] wr_cnt;
  logic [LW-1:0] ck_vlen;
  logic [1:0]    ck_mode;
  logic [AW-1:0] ck_base;
  logic          hs;

  assign hs = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_cnt  <= '0;
      wr_cnt  <= '0;
      ck_vlen <= '0;
      ck_mode <= '0;
      ck_base <= '0;
    end else if (start && !busy) begin
      hs_cnt  <= '0;
      wr_cnt  <= '0;
      ck_vlen <= (op_vlen > LW'(MAXVL)) ? LW'(MAXVL) : op_vlen;
      ck_mode <= op_mode;
      ck_base <= op_base;
    end else begin
      if (hs)     hs_cnt <= hs_cnt + LW'(1);
      if (dst_we) wr_cnt <= wr_cnt + LW'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_elem) && $stable(mem_req_we) && $stable(mem_req_wdata)); // R5
  AST_ELEM_ORDER: assert property (@(posedge clk) disable iff (rst)
    hs |-> LW'(mem_req_elem) == hs_cnt); // R4
  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> LW'(mem_req_elem) < ck_vlen); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_DST_ORDER: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> LW'(dst_addr) == wr_cnt); // R8
  AST_UNIT_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && ck_mode == 2'd0 |-> mem_req_addr == ck_base + AW'(mem_req_elem)); // R1
endmodule

bind vec_agu vec_agu_chk #(.AW(AW), .MAXVL(MAXVL)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .op_mode       (op_mode),
  .op_base       (op_base),
  .op_vlen       (op_vlen),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_we    (mem_req_we),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_elem  (mem_req_elem),
  .dst_we        (dst_we),
  .dst_addr      (dst_addr)
);

// File: tb/sim_vec_agu.sv
`timescale 1ns/1ps
module sim_vec_agu;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MAXVL = 64;
  localparam int EW = 6;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          op_store = 1'b0;
  logic [1:0]    op_mode = '0;
  logic [AW-1:0] op_base = '0;
  logic [AW-1:0] op_stride = '0;
  logic [LW-1:0] op_vlen = '0;
  logic          busy, done;
  logic [EW-1:0] vr_rd_addr;
  logic [AW-1:0] vr_idx_data;
  logic [DW-1:0] vr_src_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_we;
  logic [DW-1:0] mem_req_wdata;
  logic [EW-1:0] mem_req_elem;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          dst_we;
  logic [EW-1:0] dst_addr;
  logic [DW-1:0] dst_data;

  always #5 clk = ~clk;

  vec_agu #(.AW(AW), .DW(DW), .MAXVL(MAXVL)) u0 (.*);

  typedef struct {
    logic [AW-1:0] addr;
    logic          we;
    logic [DW-1:0] wdata;
    int            elem;
  } req_t;

  req_t          exp_q[$];
  logic [DW-1:0] pend_q[$];
  logic [DW-1:0] dst_q[$];
  logic [AW-1:0] idx_mem [MAXVL];
  logic [DW-1:0] src_mem [MAXVL];
  int  n_chk = 0, n_err = 0;
  int  cyc = 0, done_cnt = 0, dst_seen = 0;
  int  hs_n = 0, hs_first = 0, hs_last = 0;
  bit  rdy_all = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  // vector register read port model: one cycle latency
  always @(posedge clk) begin
    vr_idx_data <= idx_mem[vr_rd_addr];
    vr_src_data <= src_mem[vr_rd_addr];
  end

  function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
    return (a * 32'h9E37) ^ 32'h5A5A_1234;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / memory model, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst) begin
      mem_req_ready = rdy_all ? 1'b1 : (lfsr[0] | lfsr[4]);
      if (pend_q.size() > 0 && (rdy_all || lfsr[7])) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_q.pop_front();
        dst_q.push_back(mem_rsp_data);
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (dst_we) begin
        if (dst_q.size() == 0) begin
          check(1'b0, "R8", "unexpected dst write", dst_data, 0);
        end else begin
          logic [DW-1:0] e;
          e = dst_q.pop_front();
          check(dst_data == e, "R8", "dst data", dst_data, e);
          check(int'(dst_addr) == dst_seen, "R8", "dst element", dst_addr, dst_seen);
        end
        dst_seen++;
      end
      if (done) done_cnt++;
      if (mem_req_valid && mem_req_ready) begin
        if (hs_n == 0) hs_first = cyc;
        hs_last = cyc;
        hs_n++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected request", mem_req_addr, 0);
        end else begin
          req_t e;
          e = exp_q.pop_front();
          check(mem_req_addr == e.addr, "R1/R2/R3", "address", mem_req_addr, e.addr);
          check(int'(mem_req_elem) == e.elem, "R4", "element tag", mem_req_elem, e.elem);
          check(mem_req_we == e.we, "R7", "write flag", mem_req_we, e.we);
          if (e.we) check(mem_req_wdata == e.wdata, "R7", "store data", mem_req_wdata, e.wdata);
          if (!e.we) pend_q.push_back(mdat(e.addr));
        end
      end
    end
  end

  int cur_n;
  bit cur_load;

  task automatic launch(input bit st, input logic [1:0] md, input logic [AW-1:0] base,
                        input logic [AW-1:0] stride, input int vl);
    cur_n    = (vl > MAXVL) ? MAXVL : vl;
    cur_load = !st;
    done_cnt = 0; dst_seen = 0; hs_n = 0;
    for (int i = 0; i < cur_n; i++) begin
      req_t r;
      case (md)
        2'd1:    r.addr = base + AW'(i) * stride;
        2'd2:    r.addr = base + idx_mem[i];
        default: r.addr = base + AW'(i);
      endcase
      r.we = st; r.wdata = src_mem[i]; r.elem = i;
      exp_q.push_back(r);
    end
    @(negedge clk);
    start = 1'b1; op_store = st; op_mode = md; op_base = base;
    op_stride = stride; op_vlen = LW'(vl);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input string req);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || pend_q.size() != 0 || done_cnt == 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(t < 3000, req, "operation timed out", t, 3000);
    check(exp_q.size() == 0, "R4", "missing requests", exp_q.size(), 0);
    check(hs_n == cur_n, "R4", "request count", hs_n, cur_n);
    check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    check(dst_seen == (cur_load ? cur_n : 0), "R8", "dst write count", dst_seen,
          cur_load ? cur_n : 0);
    check(!busy, "R9", "busy after done", busy, 0);
    exp_q.delete(); pend_q.delete(); dst_q.delete();
  endtask

  initial begin
    for (int i = 0; i < MAXVL; i++) begin
      idx_mem[i] = (i % 3 == 0) ? 32'hFFFF_FF00 + 32'(i * 7) : 32'(i * i * 5);
      src_mem[i] = 32'hC0DE_0000 + 32'(i * 257);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req_valid && !dst_we, "R4", "reset state",
          {busy, done, mem_req_valid, dst_we}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 unit-stride load, ready always
    rdy_all = 1'b1;
    launch(1'b0, 2'd0, 32'd100, 32'd0, 5);
    finish_op("R1");

    // R6 back-to-back store stream
    launch(1'b1, 2'd0, 32'h2000, 32'd0, 16);
    finish_op("R6");
    check(hs_last - hs_first == 15, "R6", "handshake span", hs_last - hs_first, 15);

    // R2 strided store with wrap, stalling ready (R5 exercised)
    rdy_all = 1'b0;
    launch(1'b1, 2'd1, 32'hFFFF_FFF0, 32'd7, 9);
    finish_op("R2");
    // R2 negative stride load
    launch(1'b0, 2'd1, 32'd50, 32'hFFFF_FFFE, 12);
    finish_op("R2");

    // R3 indexed gather with R11 clamp (100 -> 64)
    launch(1'b0, 2'd2, 32'h0001_0000, 32'd0, 100);
    finish_op("R11");
    // R3 indexed scatter
    launch(1'b1, 2'd2, 32'h40, 32'd0, 20);
    finish_op("R3");
    // mode 3 behaves as unit stride
    launch(1'b1, 2'd3, 32'h77, 32'd9, 4);
    finish_op("R1");

    // R9 zero length: done in the cycle after start, no requests
    done_cnt = 0; hs_n = 0; cur_n = 0; cur_load = 1'b0;
    @(negedge clk);
    start = 1'b1; op_vlen = '0; op_mode = 2'd0; op_store = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9", "zero-length done timing", done, 1);
    finish_op("R9");

    // R10 start while busy is ignored
    rdy_all = 1'b0;
    launch(1'b0, 2'd0, 32'h300, 32'd0, 10);
    repeat (2) @(negedge clk);
    check(busy, "R10", "busy during op", busy, 1);
    start = 1'b1; op_store = 1'b1; op_mode = 2'd1; op_base = 32'h9999;
    op_stride = 32'd3; op_vlen = 7'd3;
    @(negedge clk);
    start = 1'b0;
    finish_op("R10");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule